// File: doc/BRIEF.md
# Privilege-Mode Data-Width Field Legalizer

This block keeps three 2-bit width codes of a machine status register: the machine's own base width, the width used in supervisor mode and the width used in user mode. Every write to any of them goes through a legalizer, so no register value it holds can ever describe an illegal combination. A separate port loads the machine base width. A status-register write port with a per-bit mask updates the two lower-mode codes. Parameters set the widest machine width, whether supervisor and user modes exist, which widths are legal at all, and whether either lower-mode code is a read-only mirror.

All writes that land in the same clock are resolved in a fixed chain. The new machine width is settled first. The supervisor code is then merged and clamped against it. Last, the user code is merged and clamped against the final supervisor code, or against the machine width when there is no supervisor mode. The codes are re-clamped on every clock, so a narrower machine width pulls the lower codes down at once. The effective width in bits for each mode is decoded without logic stages from the registered codes.

Top module: `xlen_field_legalizer`

## Requirements
- R1: After reset the machine code is the largest legal code not above `MAX_BASE`. The supervisor code and the user code each hold the largest legal code under their limit, or 0 where the field does not exist.
- R2: Code 1 means 32 bits, 2 means 64 and 3 means 128. The bit-width outputs follow the registered codes, so a write is visible on them in the cycle after its clock edge.
- R3: The supervisor code sits at write-data bits 35:34 and the user code at bits 33:32. Only bits whose mask bit is 1 are replaced. The other bits keep their stored value.
- R4: A machine-width write of code 0 is ignored. Any other code becomes the largest legal code not above the smaller of the request and `MAX_BASE`.
- R5: The supervisor code never exceeds the machine code. A too-large request becomes the largest legal code not above the machine code.
- R6: A machine-width change re-clamps both lower-mode codes in the same clock edge.
- R7: With supervisor mode present, the user code never exceeds the supervisor code. A supervisor change re-clamps the user code in the same edge.
- R8: Without supervisor mode, the user code is limited by the machine code.
- R9: When one clock carries a machine write and writes to both fields, they resolve in this order: machine, then supervisor, then user against the new supervisor value.
- R10: While the machine code is 1 (32-bit), both lower-mode codes read 0 and each present lower mode reports 32 bits.
- R11: A field whose mode is absent reads 0, and its bit-width output reads 0.
- R12: In mirror mode the supervisor code equals the machine code, and the user code equals its limit.
- R13: A merged request of 0 keeps the stored code. If the stored code is 0 because the machine just left 32-bit width, the field takes the largest legal code under its limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csrWrEn | input | 1 | Status-register write strobe |
| csrWrData | input | DW | Status-register write data |
| csrWrMask | input | DW | Per-bit write enable for csrWrData |
| baseWrEn | input | 1 | Machine-width write strobe |
| baseWrData | input | 2 | Requested machine width code |
| baseField | output | 2 | Current machine width code |
| supField | output | 2 | Current supervisor width code |
| usrField | output | 2 | Current user width code |
| machBits | output | 8 | Machine data width in bits |
| supBits | output | 8 | Supervisor data width in bits |
| usrBits | output | 8 | User data width in bits |

## Verification
The hardest case to reach is a single clock in which a machine-width write and writes to both lower fields land together. In that clock the supervisor clamp has to use the new machine code, and the user clamp has to use the new supervisor code. The stimulus sets this up directly with one combined write, and a pseudo-random phase produces many more such collisions. Three instances with different mode, legal-width and mirror settings receive the same stimulus. Each is compared on every clock against a behavioural model.

// File: rtl/xlen_pkg.sv
package xlen_pkg;

  typedef logic [1:0] wcode_t;

  localparam wcode_t CODE_NONE = 2'd0;
  localparam wcode_t CODE_32   = 2'd1;
  localparam wcode_t CODE_64   = 2'd2;
  localparam wcode_t CODE_128  = 2'd3;

  // Strobes and field slices from the write decoder to the datapath
  typedef struct packed {
    logic   baseWr;
    wcode_t baseReq;
    logic   supWr;
    wcode_t supData;
    wcode_t supMask;
    logic   usrWr;
    wcode_t usrData;
    wcode_t usrMask;
  } wr_strobe_t;

  // Largest legal code not above min(req, lim); 32-bit is always legal
  function automatic wcode_t clampCode(wcode_t req, wcode_t lim, logic [2:0] allowed);
    wcode_t top;
    wcode_t res;
    top = (req < lim) ? req : lim;
    res = CODE_32;
    if (top >= CODE_64 && allowed[1])  res = CODE_64;
    if (top >= CODE_128 && allowed[2]) res = CODE_128;
    return res;
  endfunction

  function automatic logic [7:0] codeToBits(wcode_t c);
    case (c)
      CODE_32:  return 8'd32;
      CODE_64:  return 8'd64;
      CODE_128: return 8'd128;
      default:  return 8'd0;
    endcase
  endfunction

endpackage

// File: rtl/xlen_wr_ctrl.sv
module xlen_wr_ctrl
  import xlen_pkg::*;
#(
  parameter int unsigned DW      = 64,
  parameter int unsigned SUP_LSB = 34,
  parameter int unsigned USR_LSB = 32
) (
  input  logic          csrWrEn,
  input  logic [DW-1:0] csrWrData,
  input  logic [DW-1:0] csrWrMask,
  input  logic          baseWrEn,
  input  wcode_t        baseWrData,
  output wr_strobe_t    strobe
);

  logic unusedBits;
  assign unusedBits = ^{csrWrData, csrWrMask};

  always_comb begin
    strobe         = '0;
    strobe.baseReq = baseWrData;
    strobe.baseWr  = baseWrEn && (baseWrData != CODE_NONE);
    strobe.supData = csrWrData[SUP_LSB +: 2];
    strobe.supMask = csrWrMask[SUP_LSB +: 2];
    strobe.supWr   = csrWrEn && (strobe.supMask != 2'b00);
    strobe.usrData = csrWrData[USR_LSB +: 2];
    strobe.usrMask = csrWrMask[USR_LSB +: 2];
    strobe.usrWr   = csrWrEn && (strobe.usrMask != 2'b00);
  end

endmodule

// File: rtl/xlen_field_dp.sv
module xlen_field_dp
  import xlen_pkg::*;
#(
  parameter int unsigned MAX_BASE   = 3,
  parameter bit          HAS_SMODE  = 1'b1,
  parameter bit          HAS_UMODE  = 1'b1,
  parameter logic [2:0]  ALLOWED    = 3'b111,
  parameter bit          SUP_MIRROR = 1'b0,
  parameter bit          USR_MIRROR = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  wr_strobe_t strobe,
  output wcode_t     baseQ,
  output wcode_t     supQ,
  output wcode_t     usrQ
);

  localparam wcode_t MAX_CODE  = wcode_t'(MAX_BASE);
  localparam wcode_t RST_BASE  = clampCode(MAX_CODE, MAX_CODE, ALLOWED);
  localparam wcode_t RST_SUP   = (!HAS_SMODE || RST_BASE == CODE_32) ? CODE_NONE : RST_BASE;
  localparam wcode_t RST_ULIM  = HAS_SMODE ? RST_SUP : RST_BASE;
  localparam wcode_t RST_USR   = (!HAS_UMODE || RST_BASE == CODE_32) ? CODE_NONE : RST_ULIM;

  wcode_t nextBase, nextSup, nextUsr;
  wcode_t supMerged, supReq, usrMerged, usrReq, usrLimit;

  // Stage 1: machine width
  always_comb begin
    nextBase = baseQ;
    if (strobe.baseWr) nextBase = clampCode(strobe.baseReq, MAX_CODE, ALLOWED);
  end

  // Stage 2: supervisor field, against the new machine width
  always_comb begin
    supMerged = (supQ & ~strobe.supMask) | (strobe.supData & strobe.supMask);
    supReq    = (strobe.supWr && supMerged != CODE_NONE) ? supMerged : supQ;
    if (supReq == CODE_NONE) supReq = nextBase;
    if (!HAS_SMODE || nextBase == CODE_32) nextSup = CODE_NONE;
    else if (SUP_MIRROR)                    nextSup = nextBase;
    else                                    nextSup = clampCode(supReq, nextBase, ALLOWED);
  end

  // Stage 3: user field, against the settled supervisor value
  always_comb begin
    usrLimit  = HAS_SMODE ? nextSup : nextBase;
    usrMerged = (usrQ & ~strobe.usrMask) | (strobe.usrData & strobe.usrMask);
    usrReq    = (strobe.usrWr && usrMerged != CODE_NONE) ? usrMerged : usrQ;
    if (usrReq == CODE_NONE) usrReq = usrLimit;
    if (!HAS_UMODE || nextBase == CODE_32) nextUsr = CODE_NONE;
    else if (USR_MIRROR)                    nextUsr = usrLimit;
    else                                    nextUsr = clampCode(usrReq, usrLimit, ALLOWED);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ <= RST_BASE;
      supQ  <= RST_SUP;
      usrQ  <= RST_USR;
    end else begin
      baseQ <= nextBase;
      supQ  <= nextSup;
      usrQ  <= nextUsr;
    end
  end

  AST_SUP_LE_BASE: assert property (@(posedge clk) disable iff (!rstN) supQ <= baseQ); // R5
  AST_USR_LE_BASE: assert property (@(posedge clk) disable iff (!rstN) usrQ <= baseQ); // R8
  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.baseWr |=> $stable(baseQ)); // R4
  AST_NARROW_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    baseQ == CODE_32 |-> (supQ == CODE_NONE && usrQ == CODE_NONE)); // R10

  generate
    if (HAS_SMODE) begin : g_sup
      AST_USR_LE_SUP: assert property (@(posedge clk) disable iff (!rstN) usrQ <= supQ); // R7
      AST_SUP_PRESENT: assert property (@(posedge clk) disable iff (!rstN)
        baseQ != CODE_32 |-> supQ != CODE_NONE); // R13
    end else begin : g_nosup
      AST_SUP_ABSENT: assert property (@(posedge clk) disable iff (!rstN) supQ == CODE_NONE); // R11
    end
    if (HAS_SMODE && SUP_MIRROR) begin : g_supmir
      AST_SUP_MIRROR: assert property (@(posedge clk) disable iff (!rstN)
        baseQ != CODE_32 |-> supQ == baseQ); // R12
    end
    if (!HAS_UMODE) begin : g_nousr
      AST_USR_ABSENT: assert property (@(posedge clk) disable iff (!rstN) usrQ == CODE_NONE); // R11
    end
  endgenerate

endmodule

// File: rtl/xlen_width_dec.sv
module xlen_width_dec
  import xlen_pkg::*;
#(
  parameter bit          HAS_SMODE = 1'b1,
  parameter bit          HAS_UMODE = 1'b1,
  parameter int unsigned WW        = 8
) (
  input  wcode_t        baseCode,
  input  wcode_t        supCode,
  input  wcode_t        usrCode,
  output logic [WW-1:0] machBits,
  output logic [WW-1:0] supBits,
  output logic [WW-1:0] usrBits
);

  logic narrow;
  assign narrow   = (baseCode == CODE_32);
  assign machBits = WW'(codeToBits(baseCode));

  generate
    if (HAS_SMODE) begin : g_sbits
      assign supBits = narrow ? WW'(32) : WW'(codeToBits(supCode));
    end else begin : g_nosbits
      logic unusedSup;
      assign unusedSup = ^supCode;
      assign supBits   = '0;
    end
    if (HAS_UMODE) begin : g_ubits
      assign usrBits = narrow ? WW'(32) : WW'(codeToBits(usrCode));
    end else begin : g_noubits
      logic unusedUsr;
      assign unusedUsr = ^usrCode;
      assign usrBits   = '0;
    end
  endgenerate

endmodule

// File: rtl/xlen_field_legalizer.sv
module xlen_field_legalizer
  import xlen_pkg::*;
#(
  parameter int unsigned DW           = 64,
  parameter int unsigned MAX_BASE     = 3,
  parameter bit          HAS_SMODE    = 1'b1,
  parameter bit          HAS_UMODE    = 1'b1,
  parameter logic [2:0]  ALLOWED_MASK = 3'b111,
  parameter bit          SUP_MIRROR   = 1'b0,
  parameter bit          USR_MIRROR   = 1'b0
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          csrWrEn,
  input  logic [DW-1:0] csrWrData,
  input  logic [DW-1:0] csrWrMask,
  input  logic          baseWrEn,
  input  logic [1:0]    baseWrData,
  output logic [1:0]    baseField,
  output logic [1:0]    supField,
  output logic [1:0]    usrField,
  output logic [7:0]    machBits,
  output logic [7:0]    supBits,
  output logic [7:0]    usrBits
);

  localparam int unsigned SUP_LSB = 34;
  localparam int unsigned USR_LSB = 32;
  localparam logic [2:0]  ALLOWED = ALLOWED_MASK | 3'b001;

  wr_strobe_t strobe;
  wcode_t     baseQ, supQ, usrQ;

  xlen_wr_ctrl #(.DW(DW), .SUP_LSB(SUP_LSB), .USR_LSB(USR_LSB)) u_ctrl (
    .csrWrEn(csrWrEn), .csrWrData(csrWrData), .csrWrMask(csrWrMask),
    .baseWrEn(baseWrEn), .baseWrData(baseWrData), .strobe(strobe)
  );

  xlen_field_dp #(
    .MAX_BASE(MAX_BASE), .HAS_SMODE(HAS_SMODE), .HAS_UMODE(HAS_UMODE),
    .ALLOWED(ALLOWED), .SUP_MIRROR(SUP_MIRROR), .USR_MIRROR(USR_MIRROR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .baseQ(baseQ), .supQ(supQ), .usrQ(usrQ)
  );

  xlen_width_dec #(.HAS_SMODE(HAS_SMODE), .HAS_UMODE(HAS_UMODE), .WW(8)) u_dec (
    .baseCode(baseQ), .supCode(supQ), .usrCode(usrQ),
    .machBits(machBits), .supBits(supBits), .usrBits(usrBits)
  );

  assign baseField = baseQ;
  assign supField  = supQ;
  assign usrField  = usrQ;

endmodule

// File: tb/xlen_field_legalizer_test.sv
module xlen_field_legalizer_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csrWrEn = 1'b0;
  logic [63:0] csrWrData = '0;
  logic [63:0] csrWrMask = '0;
  logic        baseWrEn = 1'b0;
  logic [1:0]  baseWrData = '0;
  string       tag = "R1";
  int          checks = 0;
  int          errors = 0;
  bit          started = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  logic [1:0] oB [3];
  logic [1:0] oS [3];
  logic [1:0] oU [3];
  logic [7:0] wM [3];
  logic [7:0] wS [3];
  logic [7:0] wU [3];

  // Instance configurations: max, S, U, allowed, sup mirror, usr mirror
  int cMax [3] = '{3, 3, 2};
  int cS   [3] = '{1, 0, 1};
  int cU   [3] = '{1, 1, 1};
  int cAl  [3] = '{7, 5, 7};
  int cSm  [3] = '{0, 0, 1};
  int cUm  [3] = '{0, 0, 1};

  xlen_field_legalizer uut (
    .clk(clk), .rstN(rstN), .csrWrEn(csrWrEn), .csrWrData(csrWrData), .csrWrMask(csrWrMask),
    .baseWrEn(baseWrEn), .baseWrData(baseWrData), .baseField(oB[0]), .supField(oS[0]),
    .usrField(oU[0]), .machBits(wM[0]), .supBits(wS[0]), .usrBits(wU[0]));

  xlen_field_legalizer #(.HAS_SMODE(1'b0), .ALLOWED_MASK(3'b101)) uutB (
    .clk(clk), .rstN(rstN), .csrWrEn(csrWrEn), .csrWrData(csrWrData), .csrWrMask(csrWrMask),
    .baseWrEn(baseWrEn), .baseWrData(baseWrData), .baseField(oB[1]), .supField(oS[1]),
    .usrField(oU[1]), .machBits(wM[1]), .supBits(wS[1]), .usrBits(wU[1]));

  xlen_field_legalizer #(.MAX_BASE(2), .SUP_MIRROR(1'b1), .USR_MIRROR(1'b1)) uutC (
    .clk(clk), .rstN(rstN), .csrWrEn(csrWrEn), .csrWrData(csrWrData), .csrWrMask(csrWrMask),
    .baseWrEn(baseWrEn), .baseWrData(baseWrData), .baseField(oB[2]), .supField(oS[2]),
    .usrField(oU[2]), .machBits(wM[2]), .supBits(wS[2]), .usrBits(wU[2]));

  // Reference model state
  int mB [3];
  int mS [3];
  int mU [3];

  function automatic int refClamp(int req, int lim, int allow);
    int top = (req < lim) ? req : lim;
    for (int c = top; c >= 2; c--) if (((allow >> (c - 1)) & 1) == 1) return c;
    return 1;
  endfunction

  function automatic int refBits(int c);
    return (c == 0) ? 0 : (32 << (c - 1));
  endfunction

  function automatic int mergeReq(int old, int d, int m);
    int mg = (old & ~m & 3) | (d & m);
    return (mg != 0) ? mg : old;
  endfunction

  always @(posedge clk) begin
    for (int i = 0; i < 3; i++) begin
      int nb, ns, nu, req, lim;
      if (!rstN) begin
        nb = refClamp(cMax[i], cMax[i], cAl[i] | 1);
        ns = (cS[i] == 0 || nb == 1) ? 0 : nb;
        lim = (cS[i] != 0) ? ns : nb;
        nu = (cU[i] == 0 || nb == 1) ? 0 : lim;
      end else begin
        nb = mB[i];
        if (baseWrEn && baseWrData != 0) nb = refClamp(int'(baseWrData), cMax[i], cAl[i] | 1);
        if (cS[i] == 0 || nb == 1) ns = 0;
        else if (cSm[i] != 0) ns = nb;
        else begin
          req = mS[i];
          if (csrWrEn) req = mergeReq(mS[i], int'(csrWrData[35:34]), int'(csrWrMask[35:34]));
          if (req == 0) req = nb;
          ns = refClamp(req, nb, cAl[i] | 1);
        end
        lim = (cS[i] != 0) ? ns : nb;
        if (cU[i] == 0 || nb == 1) nu = 0;
        else if (cUm[i] != 0) nu = lim;
        else begin
          req = mU[i];
          if (csrWrEn) req = mergeReq(mU[i], int'(csrWrData[33:32]), int'(csrWrMask[33:32]));
          if (req == 0) req = lim;
          nu = refClamp(req, lim, cAl[i] | 1);
        end
      end
      mB[i] = nb; mS[i] = ns; mU[i] = nu;
    end
    started = 1'b1;
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      for (int i = 0; i < 3; i++) begin
        string tS, tU;
        int eSw, eUw;
        tS = (i == 1) ? "R11" : (i == 2) ? "R12" : tag;
        tU = (i == 1) ? "R8"  : (i == 2) ? "R12" : tag;
        eSw = (cS[i] == 0) ? 0 : (mB[i] == 1) ? 32 : refBits(mS[i]);
        eUw = (cU[i] == 0) ? 0 : (mB[i] == 1) ? 32 : refBits(mU[i]);
        chk(tag, $sformatf("inst%0d base", i), int'(oB[i]), mB[i]);
        chk(tS,  $sformatf("inst%0d sup", i),  int'(oS[i]), mS[i]);
        chk(tU,  $sformatf("inst%0d usr", i),  int'(oU[i]), mU[i]);
        chk("R2", $sformatf("inst%0d machBits", i), int'(wM[i]), refBits(mB[i]));
        chk("R2", $sformatf("inst%0d supBits", i),  int'(wS[i]), eSw);
        chk("R2", $sformatf("inst%0d usrBits", i),  int'(wU[i]), eUw);
      end
    end
  end

  task automatic step(string t, bit en, logic [1:0] sd, logic [1:0] sm,
                      logic [1:0] ud, logic [1:0] um, bit be, logic [1:0] bd);
    @(posedge clk);
    #5;
    tag        = t;
    csrWrEn    = en;
    csrWrData  = {28'h0, sd, ud, 32'hFFFF_FFFF};
    csrWrMask  = {28'h0, sm, um, 32'hFFFF_FFFF};
    baseWrEn   = be;
    baseWrData = bd;
  endtask

  task automatic idle(string t);
    step(t, 1'b0, 2'b00, 2'b00, 2'b00, 2'b00, 1'b0, 2'b00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5 rstN = 1'b1;
    idle("R1");
    step("R3", 1, 2'b10, 2'b11, 2'b00, 2'b00, 0, 2'b00);  idle("R3");
    step("R3", 1, 2'b01, 2'b01, 2'b01, 2'b11, 0, 2'b00);  idle("R3");
    step("R6", 0, 2'b00, 2'b00, 2'b00, 2'b00, 1, 2'b10);  idle("R6");
    step("R5", 1, 2'b11, 2'b11, 2'b00, 2'b00, 0, 2'b00);  idle("R5");
    step("R10", 0, 2'b00, 2'b00, 2'b00, 2'b00, 1, 2'b01); idle("R10");
    step("R13", 0, 2'b00, 2'b00, 2'b00, 2'b00, 1, 2'b11); idle("R13");
    step("R9", 1, 2'b11, 2'b11, 2'b11, 2'b11, 1, 2'b10);  idle("R9");
    step("R7", 1, 2'b01, 2'b11, 2'b00, 2'b00, 0, 2'b00);  idle("R7");
    step("R7", 1, 2'b00, 2'b00, 2'b11, 2'b11, 0, 2'b00);  idle("R7");
    step("R4", 0, 2'b00, 2'b00, 2'b00, 2'b00, 1, 2'b00);  idle("R4");
    step("R13", 1, 2'b00, 2'b11, 2'b00, 2'b11, 0, 2'b00); idle("R13");
    step("R12", 1, 2'b11, 2'b11, 2'b01, 2'b11, 1, 2'b11); idle("R12");
    begin
      logic [15:0] lfsr = 16'hACE1;
      for (int k = 0; k < 400; k++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        step("R9", lfsr[0], lfsr[2:1], lfsr[4:3], lfsr[6:5], lfsr[8:7], lfsr[9], lfsr[11:10]);
      end
    end
    idle("R9");
    @(posedge clk);
    @(negedge clk);
    #1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule